// File: doc/BRIEF.md
# NaN Classifier and Quieter

This unit inspects one floating-point word per cycle and tells the surrounding datapath whether that word is a quiet NaN, a signaling NaN, or something else. A two-bit select chooses one of four formats: half, bfloat16, single or double. Two run-time mode bits change how NaNs are read. The polarity mode sets what a 1 in the top fraction bit means. The no-signaling mode treats every NaN as quiet.

For the same word, the unit also returns a quieted copy of the operand, the default NaN pattern of the chosen format, and an invalid-operation flag. The flag goes high when the operand is classified as signaling. All results come from one register stage. They appear in the cycle after the input is presented, qualified by an output valid.

The output valid comes from a two-state machine. The states are ST_EMPTY (no result held) and ST_FULL (a result from the previous cycle is on the outputs). There are two transitions:
- GO_FULL: taken from either state when `in_valid` is high.
- GO_EMPTY: taken from either state when `in_valid` is low.

Reset forces ST_EMPTY.

Top module: `nanq_unit`

## Requirements
- R1: The format select decodes as follows: 00 is half (5 exponent bits, 10 fraction bits), 01 is bfloat16 (8 and 7), 10 is single (8 and 23) and 11 is double (11 and 52). The sign is the top bit of each width, the exponent sits directly below the sign, and the fraction occupies the low bits. Narrow operands sit in the low bits of `in_word`, and the bits above them are ignored. A word whose exponent is not all ones reports neither NaN flag.
- R2: With polarity 0 and no-signaling mode off, the quiet flag is set when the exponent is all ones and the top fraction bit is 1. The signaling flag is set when the exponent is all ones, the top fraction bit is 0, and the lower fraction bits are nonzero.
- R3: With polarity 1 and no-signaling mode off, the signaling flag is set when the exponent is all ones and the top fraction bit is 1. The quiet flag is set only when the top fraction bit is 0 and the lower fraction bits are nonzero. An all-ones exponent with a zero fraction (infinity) reports neither flag.
- R4: With no-signaling mode on, the quiet flag is set for any NaN (all-ones exponent, nonzero fraction), and the signaling flag is always 0.
- R5: With polarity 0, the quieted output of a signaling NaN is the operand with the top fraction bit set.
- R6: With polarity 1, the quieted output of a signaling NaN is the format's default NaN.
- R7: For an operand that is not signaling, the quieted output equals the operand. It is zero-extended from the format width to 64 bits.
- R8: The default NaN output has sign 0 and an all-ones exponent. Its fraction has only the top bit set under polarity 0, and every bit except the top under polarity 1. It is zero-extended to 64 bits.
- R9: The invalid flag is high exactly when the operand is classified as a signaling NaN.
- R10: Results appear one clock after `in_valid`, with `out_valid` high for that cycle only. When `in_valid` is low, `out_valid` falls and the data outputs hold their last values. A synchronous active-high reset clears `out_valid` and all result outputs.
- R11: The quiet and signaling flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | 64 | Operand, narrow formats in the low bits |
| in_fmt | input | 2 | Format select (00 half, 01 bfloat16, 10 single, 11 double) |
| in_snan_inv | input | 1 | Polarity mode: 1 means a set top fraction bit marks signaling |
| in_no_snan | input | 1 | Treat every NaN as quiet |
| out_valid | output | 1 | Result valid |
| out_is_qnan | output | 1 | Operand is a quiet NaN |
| out_is_snan | output | 1 | Operand is a signaling NaN |
| out_invalid | output | 1 | Invalid-operation flag |
| out_quieted | output | 64 | Quieted copy of the operand |
| out_dflt_nan | output | 64 | Default NaN of the chosen format |

## Verification
Several properties are checked on every cycle:
- The two NaN flags are never high together.
- The invalid flag follows the signaling flag.
- `out_valid` tracks `in_valid` with exactly one cycle of delay.
- No-signaling mode never yields a signaling result.
- A non-signaling operand passes through unchanged.
- A signaling operand always comes back altered.

Other behaviour can only be shown by the bench's sweeps, because it depends on exact bit patterns:
- Whether each pattern lands in the right class under each polarity.
- Infinity under inverted polarity.
- The exact quieted and default-NaN values.
- Holding the outputs while idle.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    localparam int WORD_W  = 64;
    localparam int NUM_FMT = 4;
    localparam int FMT_W   = $clog2(NUM_FMT);

    typedef enum logic [FMT_W-1:0] {
        FMT_HALF   = 2'b00,
        FMT_BF16   = 2'b01,
        FMT_SINGLE = 2'b10,
        FMT_DOUBLE = 2'b11
    } nanq_fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } nanq_state_e;

    typedef struct packed {
        logic              is_q;
        logic              is_s;
        logic [WORD_W-1:0] quieted;
        logic [WORD_W-1:0] dflt;
    } nanq_res_t;

    function automatic int fmt_exp_w(int f);
        case (f)
            0:       return 5;
            1:       return 8;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_frac_w(int f);
        case (f)
            0:       return 10;
            1:       return 7;
            2:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/nanq_lane.sv
module nanq_lane
    import nanq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] word,
    input  logic         snan_inv,
    input  logic         no_snan,
    output nanq_res_t    res
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              top_bit;
    logic              low_nz;
    logic              exp_ones;
    logic              any_nan;
    logic              is_q;
    logic              is_s;
    logic [W-1:0]      dflt_w;
    logic [W-1:0]      quiet_w;

    assign exp_f    = word[W-2 -: EXP_W];
    assign frac_f   = word[FRAC_W-1:0];
    assign top_bit  = frac_f[FRAC_W-1];
    assign low_nz   = |frac_f[FRAC_W-2:0];
    assign exp_ones = &exp_f;
    assign any_nan  = exp_ones && (top_bit || low_nz);

    // classification under the three mode combinations
    always_comb begin
        if (no_snan) begin
            is_q = any_nan;
            is_s = 1'b0;
        end else if (!snan_inv) begin
            is_q = exp_ones && top_bit;
            is_s = exp_ones && !top_bit && low_nz;
        end else begin
            is_q = exp_ones && !top_bit && low_nz;
            is_s = exp_ones && top_bit;
        end
    end

    // default NaN of this format
    always_comb begin
        dflt_w                 = '0;
        dflt_w[W-2 -: EXP_W]   = '1;
        if (snan_inv) begin
            dflt_w[FRAC_W-2:0] = '1;
        end else begin
            dflt_w[FRAC_W-1]   = 1'b1;
        end
    end

    // quieting: set the top bit, or fall back to the default NaN
    always_comb begin
        quiet_w = word;
        if (is_s) begin
            if (snan_inv) begin
                quiet_w = dflt_w;
            end else begin
                quiet_w[FRAC_W-1] = 1'b1;
            end
        end
    end

    always_comb begin
        res           = '0;
        res.is_q      = is_q;
        res.is_s      = is_s;
        res.quieted[W-1:0] = quiet_w;
        res.dflt[W-1:0]    = dflt_w;
    end

endmodule

// File: rtl/nanq_core.sv
module nanq_core
    import nanq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [FMT_W-1:0]  fmt,
    input  logic              snan_inv,
    input  logic              no_snan,
    output nanq_res_t         res
);

    nanq_res_t lane_res [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);
        nanq_lane #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_lane (
            .word     (word[EW+FW:0]),
            .snan_inv (snan_inv),
            .no_snan  (no_snan),
            .res      (lane_res[g])
        );
    end

    assign res = lane_res[fmt];

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
    import nanq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       in_word,
    input  logic [1:0]        in_fmt,
    input  logic              in_snan_inv,
    input  logic              in_no_snan,
    output logic              out_valid,
    output logic              out_is_qnan,
    output logic              out_is_snan,
    output logic              out_invalid,
    output logic [63:0]       out_quieted,
    output logic [63:0]       out_dflt_nan
);

    nanq_res_t   comb_res;
    nanq_res_t   res_q;
    logic        inval_q;
    nanq_state_e state_q;
    nanq_state_e state_d;

    nanq_core u_core (
        .word     (in_word),
        .fmt      (in_fmt),
        .snan_inv (in_snan_inv),
        .no_snan  (in_no_snan),
        .res      (comb_res)
    );

    // next state: GO_FULL on an operand, GO_EMPTY otherwise
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            inval_q <= 1'b0;
        end else if (in_valid) begin
            res_q   <= comb_res;
            inval_q <= comb_res.is_s;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_FULL:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    assign out_is_qnan  = res_q.is_q;
    assign out_is_snan  = res_q.is_s;
    assign out_invalid  = inval_q;
    assign out_quieted  = res_q.quieted;
    assign out_dflt_nan = res_q.dflt;

endmodule

// File: rtl/nanq_chk.sv
module nanq_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_word,
    input logic [1:0]  in_fmt,
    input logic        in_no_snan,
    input logic        out_valid,
    input logic        out_is_qnan,
    input logic        out_is_snan,
    input logic        out_invalid,
    input logic [63:0] out_quieted
);

    function automatic logic [63:0] fmt_mask(logic [1:0] f);
        case (f)
            2'b00, 2'b01: return 64'h0000_0000_0000_FFFF;
            2'b10:        return 64'h0000_0000_FFFF_FFFF;
            default:      return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_is_qnan, out_is_snan})); // R11

    AST_INVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_invalid == out_is_snan)); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R10

    AST_NO_SNAN_MODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_no_snan) |=> !out_is_snan); // R4

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_is_snan ||
            out_quieted == ($past(in_word) & fmt_mask($past(in_fmt))))); // R7

    AST_SNAN_ALTERED: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_is_snan ||
            out_quieted != ($past(in_word) & fmt_mask($past(in_fmt))))); // R5

endmodule

bind nanq_unit nanq_chk u_chk (.*);

// File: tb/test_nanq_unit.sv
`timescale 1ns/1ps
module test_nanq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_word;
    logic [1:0]  in_fmt;
    logic        in_snan_inv;
    logic        in_no_snan;
    logic        out_valid;
    logic        out_is_qnan;
    logic        out_is_snan;
    logic        out_invalid;
    logic [63:0] out_quieted;
    logic [63:0] out_dflt_nan;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nanq_unit i_nanq_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_fmt(in_fmt), .in_snan_inv(in_snan_inv), .in_no_snan(in_no_snan),
        .out_valid(out_valid), .out_is_qnan(out_is_qnan),
        .out_is_snan(out_is_snan), .out_invalid(out_invalid),
        .out_quieted(out_quieted), .out_dflt_nan(out_dflt_nan)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference computed from the field widths (R1)
    task automatic ref_model(input logic [63:0] word, input logic [1:0] fmt,
                             input logic inv, input logic nos,
                             output logic q, output logic s,
                             output logic [63:0] quiet, output logic [63:0] dflt);
        int ew, fw, w;
        logic [63:0] m, v, e, f, low;
        logic msb, eones, nan;
        case (fmt)
            2'b00: begin ew = 5;  fw = 10; end
            2'b01: begin ew = 8;  fw = 7;  end
            2'b10: begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
        w = 1 + ew + fw;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        v = word & m;
        e = (v >> fw) & ((64'd1 << ew) - 64'd1);
        f = v & ((64'd1 << fw) - 64'd1);
        msb = f[fw-1];
        low = f & ((64'd1 << (fw-1)) - 64'd1);
        eones = (e == ((64'd1 << ew) - 64'd1));
        nan = eones && (f != 0);
        if (nos) begin
            q = nan; s = 1'b0;
        end else if (!inv) begin
            q = eones && msb; s = eones && !msb && (low != 0);
        end else begin
            s = eones && msb; q = eones && !msb && (low != 0);
        end
        dflt = (((64'd1 << ew) - 64'd1) << fw) |
               (inv ? ((64'd1 << (fw-1)) - 64'd1) : (64'd1 << (fw-1)));
        quiet = s ? (inv ? dflt : (v | (64'd1 << (fw-1)))) : v;
    endtask

    task automatic apply(logic [63:0] word, logic [1:0] fmt, logic inv, logic nos);
        logic q, s;
        logic [63:0] qv, dv;
        string ctag, qtag;
        ref_model(word, fmt, inv, nos, q, s, qv, dv);
        @(negedge clk);
        in_valid = 1'b1; in_word = word; in_fmt = fmt;
        in_snan_inv = inv; in_no_snan = nos;
        @(posedge clk);
        #1;
        ctag = nos ? "R4" : (inv ? "R3" : "R2");
        if (!q && !s) ctag = {ctag, "/R1"};
        qtag = s ? (inv ? "R6" : "R5") : "R7";
        chk("R10 valid", 64'(out_valid), 64'd1);
        chk({ctag, " quiet flag"}, 64'(out_is_qnan), 64'(q));
        chk({ctag, " signal flag"}, 64'(out_is_snan), 64'(s));
        chk("R9 invalid", 64'(out_invalid), 64'(s));
        chk("R11 exclusive", 64'(out_is_qnan && out_is_snan), 64'd0);
        chk({qtag, " quieted"}, out_quieted, qv);
        chk("R8 default nan", out_dflt_nan, dv);
    endtask

    initial begin
        #(4 * 195000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_fmt = '0;
        in_snan_inv = 1'b0; in_no_snan = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset valid", 64'(out_valid), 64'd0);
        chk("R10 reset quieted", out_quieted, 64'd0);
        chk("R10 reset flags", 64'({out_is_qnan, out_is_snan, out_invalid}), 64'd0);
        chk("R10 reset dflt", out_dflt_nan, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // field pattern sweep over every format and mode
        for (int fm = 0; fm < 4; fm++) begin
            for (int md = 0; md < 4; md++) begin
                for (int ec = 0; ec < 3; ec++) begin
                    for (int fc = 0; fc < 6; fc++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            int ew, fw, w;
                            logic [63:0] e, f, word, m;
                            case (fm)
                                0: begin ew = 5;  fw = 10; end
                                1: begin ew = 8;  fw = 7;  end
                                2: begin ew = 8;  fw = 23; end
                                default: begin ew = 11; fw = 52; end
                            endcase
                            w = 1 + ew + fw;
                            m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
                            e = (ec == 0) ? ((64'd1 << ew) - 1) :
                                (ec == 1) ? ((64'd1 << ew) - 2) : 64'd0;
                            case (fc)
                                0: f = 64'd0;
                                1: f = 64'd1 << (fw-1);
                                2: f = 64'd1;
                                3: f = (64'd1 << (fw-1)) | 64'd1;
                                4: f = (64'd1 << fw) - 1;
                                default: f = (64'd1 << (fw-1)) - 1;
                            endcase
                            word = (64'(sg) << (w-1)) | (e << fw) | f;
                            word = word | (64'hA5C3_5A3C_9669_F00F & ~m); // R1 upper bits ignored
                            apply(word, 2'(fm), md[0], md[1]);
                        end
                    end
                end
            end
        end

        // hold while idle (R10)
        apply(64'h0000_0000_7FA0_0001, 2'b10, 1'b0, 1'b0);
        held = out_quieted;
        @(negedge clk);
        in_valid = 1'b0; in_word = '1;
        @(posedge clk);
        #1;
        chk("R10 idle valid", 64'(out_valid), 64'd0);
        chk("R10 idle hold", out_quieted, held);

        // exhaustive half, default polarity
        for (int i = 0; i < 65536; i++) apply(64'(i), 2'b00, 1'b0, 1'b0);
        // exhaustive bfloat16, inverted polarity
        for (int i = 0; i < 65536; i++) apply(64'(i), 2'b01, 1'b1, 1'b0);

        @(negedge clk);
        in_valid = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule